// File: doc/BRIEF.md
# Register-Triggered Multiply/Divide Unit

This block is an arithmetic helper that a host drives over a byte-wide register bus. The host loads the operands one byte at a time: a 32-bit dividend whose lower half also serves as the multiplicand, a 16-bit multiplier and a 16-bit divisor. Writing the most significant byte of the multiplier launches a 16x16 multiply with a 32-bit product. Writing the most significant byte of the divisor launches a 32/16 divide, which yields a 32-bit quotient and a 16-bit remainder.

A mode bit selects two's-complement or unsigned arithmetic. The multiply runs on a sequential shift-add engine and the divide on a sequential restoring engine. Both engines work on magnitudes, and the signs are fixed up when the result is stored. A status byte shows a busy flag while an engine iterates. It also holds a sticky flag that the first completed multiply sets. Every register reads back combinationally at its byte offset, and reads have no side effects.

Top module: `mdu_unit`

## Requirements
- R1: After reset every one of the 16 byte registers (offsets 0x0 to 0xF) reads 0x00.
- R2: Register map: dividend bytes at offsets 0x0–0x3 (least significant byte first; 0x0–0x1 are also the multiplicand), multiplier at 0x4–0x5, divisor at 0x6–0x7, result at 0x8–0xB, remainder at 0xC–0xD, mode at 0xE, status at 0xF. Operand bytes read back what was written. Only mode bit 0 is stored; the other mode bits read 0. Writes to the result, remainder and status offsets have no effect.
- R3: A write to offset 0x5 starts an unsigned multiply when mode bit 0 is clear. Seventeen clock edges after the triggering write edge, the result holds the 32-bit product of dividend[15:0] and the multiplier. The remainder is left unchanged.
- R4: With mode bit 0 set, the multiply treats both 16-bit operands as two's complement, and the result holds the 32-bit signed product.
- R5: A write to offset 0x7 starts a divide. Thirty-three clock edges after the triggering write edge, the result holds the 32-bit quotient and the remainder holds the 16-bit remainder. With mode bit 0 clear, both are unsigned.
- R6: In signed mode the 32-bit dividend and the 16-bit divisor are two's complement. The quotient truncates toward zero. The remainder takes the sign of the dividend and is stored as its low 16 bits.
- R7: When the divisor is zero, in either mode, the quotient is 0 and the remainder equals dividend[15:0].
- R8: Status bit 7 becomes 1 on the triggering write edge and stays 1 until the completing edge, where it clears. A completed multiply sets status bit 0. A completed divide leaves status bit 0 as it was. All other status bits read 0.
- R9: Writing a low operand byte (0x4 or 0x6) starts nothing. Changes to the operands or the mode made while an operation runs do not alter that operation's result.
- R10: A new trigger while an operation runs abandons the old one. The result is that of the new operation, delivered with the full latency counted from the new trigger. This holds for any mix of multiply and divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one byte register |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Combinational read data for bus_addr |

## Verification
The trigger write is taken on one rising edge. For a multiply, the product and the status change become visible exactly 17 edges later; for a divide, 33 edges later. The driver notes the cycle number of the trigger edge and pushes an expected item with that due cycle into a queue. The monitor waits to the falling edge after edge due−1 and confirms that the busy bit is still set. On the falling edge after the due edge, it compares the result, remainder and status bytes, so an answer that arrives one cycle early or late is caught. Restart cases queue only the surviving operation, with its due cycle taken from the second trigger.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int NUM_W  = 32;
  localparam int OPR_W  = 16;
  localparam int NUM_B  = NUM_W / BYTE_W;
  localparam int OPR_B  = OPR_W / BYTE_W;
  localparam int REG_N  = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_NUM = '0;
  localparam logic [ADDR_W-1:0] A_MLT = ADDR_W'(int'(A_NUM) + NUM_B);
  localparam logic [ADDR_W-1:0] A_DVS = ADDR_W'(int'(A_MLT) + OPR_B);
  localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(int'(A_DVS) + OPR_B);
  localparam logic [ADDR_W-1:0] A_REM = ADDR_W'(int'(A_RES) + NUM_B);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(int'(A_REM) + OPR_B);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(int'(A_FLG) + 1);

  localparam int ST_BUSY  = 7;
  localparam int ST_MDONE = 0;

  // magnitude of a two's complement word
  function automatic logic [NUM_W-1:0] mag_num(input logic [NUM_W-1:0] v);
    return v[NUM_W-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [OPR_W-1:0] mag_opr(input logic [OPR_W-1:0] v);
    return v[OPR_W-1] ? (~v + 1'b1) : v;
  endfunction

  // conditional negation used when re-applying the sign
  function automatic logic [NUM_W-1:0] sgn_num(input logic [NUM_W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [OPR_W-1:0] sgn_opr(input logic [OPR_W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

endpackage

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           abort,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  mcand;
  logic [W:0]    psum;

  // add the multiplicand into the upper half when the current multiplier bit is set
  always_comb psum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      cnt   <= '0;
      mcand <= '0;
      prod  <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        mcand <= op_a;
        prod  <= {{W{1'b0}}, op_b};
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        prod <= {psum, prod[W-1:1]};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          fin,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] den_q;
  logic [DW:0]   shifted;
  logic [DW:0]   trial;
  logic          fits;

  // one restoring step: shift in the next numerator bit, trial-subtract, keep or restore
  always_comb begin
    shifted = {rem, quo[NW-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = (shifted >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      cnt   <= '0;
      den_q <= '0;
      quo   <= '0;
      rem   <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        den_q <= den;
        quo   <= num;
        rem   <= '0;
        cnt   <= CW'(NW);
        busy  <= 1'b1;
      end else if (abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        rem <= fits ? trial[DW-1:0] : shifted[DW-1:0];
        quo <= {quo[NW-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_regfile.sv
module mdu_regfile
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NUM_W-1:0]  res_i,
  input  logic [OPR_W-1:0]  rem_i,
  input  logic [BYTE_W-1:0] sts_i,
  output logic [NUM_W-1:0]  num_q,
  output logic [OPR_W-1:0]  mlt_nx,
  output logic [OPR_W-1:0]  dvs_nx,
  output logic              flg_q,
  output logic              mul_fire,
  output logic              div_fire,
  output logic [BYTE_W-1:0] rdata
);
  logic [OPR_W-1:0]  mlt_q;
  logic [OPR_W-1:0]  dvs_q;
  logic [BYTE_W-1:0] bank [REG_N];

  // the top byte of each second operand is the launch strobe
  assign mul_fire = wr && (addr == ADDR_W'(int'(A_MLT) + OPR_B - 1));
  assign div_fire = wr && (addr == ADDR_W'(int'(A_DVS) + OPR_B - 1));

  // operand values including a byte written on this very edge, for the engines
  always_comb begin
    mlt_nx = mlt_q;
    dvs_nx = dvs_q;
    for (int i = 0; i < OPR_B; i++) begin
      if (wr && addr == ADDR_W'(int'(A_MLT) + i)) mlt_nx[i*BYTE_W +: BYTE_W] = wdata;
      if (wr && addr == ADDR_W'(int'(A_DVS) + i)) dvs_nx[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      mlt_q <= '0;
      dvs_q <= '0;
      flg_q <= 1'b0;
    end else begin
      mlt_q <= mlt_nx;
      dvs_q <= dvs_nx;
      for (int i = 0; i < NUM_B; i++) begin
        if (wr && addr == ADDR_W'(int'(A_NUM) + i)) num_q[i*BYTE_W +: BYTE_W] <= wdata;
      end
      if (wr && addr == A_FLG) flg_q <= wdata[0];
    end
  end

  // read bank, one byte per offset
  always_comb begin
    for (int k = 0; k < REG_N; k++) bank[k] = '0;
    for (int i = 0; i < NUM_B; i++) begin
      bank[int'(A_NUM) + i] = num_q[i*BYTE_W +: BYTE_W];
      bank[int'(A_RES) + i] = res_i[i*BYTE_W +: BYTE_W];
    end
    for (int i = 0; i < OPR_B; i++) begin
      bank[int'(A_MLT) + i] = mlt_q[i*BYTE_W +: BYTE_W];
      bank[int'(A_DVS) + i] = dvs_q[i*BYTE_W +: BYTE_W];
      bank[int'(A_REM) + i] = rem_i[i*BYTE_W +: BYTE_W];
    end
    bank[A_FLG] = BYTE_W'(flg_q);
    bank[A_STS] = sts_i;
  end

  assign rdata = bank[addr];
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic [NUM_W-1:0]  num_q;
  logic [OPR_W-1:0]  mlt_nx, dvs_nx;
  logic              flg_q;
  logic              mul_fire, div_fire, launch_any;
  logic              mul_busy, div_busy, mul_fin, div_fin;
  logic [OPR_W-1:0]  mul_a, mul_b, div_d;
  logic [NUM_W-1:0]  div_n;
  logic [NUM_W-1:0]  prod_u, quo_u;
  logic [OPR_W-1:0]  rem_u;
  logic [NUM_W-1:0]  res_q;
  logic [OPR_W-1:0]  rem_q;
  logic [BYTE_W-1:0] sts_q;
  logic              busy_q, mdone_q;
  logic              mul_neg_q, quo_neg_q, rem_neg_q, dz_q;
  logic [OPR_W-1:0]  dz_rem_q;

  mdu_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .res_i    (res_q),
    .rem_i    (rem_q),
    .sts_i    (sts_q),
    .num_q    (num_q),
    .mlt_nx   (mlt_nx),
    .dvs_nx   (dvs_nx),
    .flg_q    (flg_q),
    .mul_fire (mul_fire),
    .div_fire (div_fire),
    .rdata    (bus_rdata)
  );

  assign launch_any = mul_fire | div_fire;

  // operand magnitudes fed to the unsigned engines
  always_comb begin
    mul_a = num_q[OPR_W-1:0];
    mul_b = mlt_nx;
    div_n = num_q;
    div_d = dvs_nx;
    if (flg_q) begin
      mul_a = mag_opr(mul_a);
      mul_b = mag_opr(mul_b);
      div_n = mag_num(div_n);
      div_d = mag_opr(div_d);
    end
  end

  mdu_mul_seq #(.W(OPR_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_fire),
    .abort (div_fire),
    .op_a  (mul_a),
    .op_b  (mul_b),
    .busy  (mul_busy),
    .fin   (mul_fin),
    .prod  (prod_u)
  );

  mdu_div_seq #(.NW(NUM_W), .DW(OPR_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_fire),
    .abort (mul_fire),
    .num   (div_n),
    .den   (div_d),
    .busy  (div_busy),
    .fin   (div_fin),
    .quo   (quo_u),
    .rem   (rem_u)
  );

  // sign and zero-divisor context captured at launch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_neg_q <= 1'b0;
      quo_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
      dz_q      <= 1'b0;
      dz_rem_q  <= '0;
    end else begin
      if (mul_fire) mul_neg_q <= flg_q & (num_q[OPR_W-1] ^ mlt_nx[OPR_W-1]);
      if (div_fire) begin
        quo_neg_q <= flg_q & (num_q[NUM_W-1] ^ dvs_nx[OPR_W-1]);
        rem_neg_q <= flg_q & num_q[NUM_W-1];
        dz_q      <= (dvs_nx == '0);
        dz_rem_q  <= num_q[OPR_W-1:0];
      end
    end
  end

  // result, remainder and status; a fresh launch overrides a completion on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      mdone_q <= 1'b0;
    end else if (launch_any) begin
      busy_q <= 1'b1;
    end else if (mul_fin) begin
      res_q   <= sgn_num(prod_u, mul_neg_q);
      busy_q  <= 1'b0;
      mdone_q <= 1'b1;
    end else if (div_fin) begin
      res_q  <= dz_q ? '0 : sgn_num(quo_u, quo_neg_q);
      rem_q  <= dz_q ? dz_rem_q : sgn_opr(rem_u, rem_neg_q);
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    sts_q           = '0;
    sts_q[ST_BUSY]  = busy_q;
    sts_q[ST_MDONE] = mdone_q;
  end
endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk
  import mdu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              mul_fire,
  input logic              div_fire,
  input logic              mul_fin,
  input logic              div_fin,
  input logic              mul_busy,
  input logic              div_busy,
  input logic              flg_q,
  input logic [NUM_W-1:0]  res_q,
  input logic [BYTE_W-1:0] sts_q
);
  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_fire || div_fire) |=> sts_q[ST_BUSY]);

  // R8
  mul_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_fin && !mul_fire && !div_fire) |=> (sts_q[ST_MDONE] && !sts_q[ST_BUSY]));

  // R8
  div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_fin && !mul_fire && !div_fire) |=>
      (!sts_q[ST_BUSY] && sts_q[ST_MDONE] == $past(sts_q[ST_MDONE])));

  // R10
  one_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_busy, div_busy}));

  // R2
  flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FLG) |=> (flg_q == $past(bus_wdata[0])));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul_fin && !div_fin) |=> $stable(res_q));
endmodule

bind mdu_unit mdu_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mul_fire  (mul_fire),
  .div_fire  (div_fire),
  .mul_fin   (mul_fin),
  .div_fin   (div_fin),
  .mul_busy  (mul_busy),
  .div_busy  (div_busy),
  .flg_q     (flg_q),
  .res_q     (res_q),
  .sts_q     (sts_q)
);

// File: tb/mdu_unit_test.sv
`timescale 1ns/100ps
module mdu_unit_test;
  localparam int MUL_LAT = 17;
  localparam int DIV_LAT = 33;
  localparam logic [3:0] O_NUM = 4'h0, O_MLT = 4'h4, O_DVS = 4'h6,
                         O_RES = 4'h8, O_REM = 4'hC, O_FLG = 4'hE, O_STS = 4'hF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  mdu_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int unsigned due;
    logic [31:0] res;
    logic [15:0] rem;
    logic        st0;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_res = '0;
  logic [15:0] m_rem = '0;
  logic        m_st0 = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic rd32(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(a + 4'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] b;
    for (int i = 0; i < 2; i++) begin
      rd(a + 4'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  // driver: launches a multiply, optionally queues its expected outcome
  task automatic go_mul(input logic [15:0] a, input logic [15:0] b, input bit sgn,
                        input bit keep, input string tag);
    exp_t e;
    wr(O_FLG, {7'b0, sgn});
    wr(O_NUM, a[7:0]);
    wr(O_NUM + 4'd1, a[15:8]);
    wr(O_MLT, b[7:0]);
    wr(O_MLT + 4'd1, b[15:8]);
    if (keep) begin
      if (sgn) m_res = 32'(int'($signed(a)) * int'($signed(b)));
      else     m_res = {16'b0, a} * {16'b0, b};
      m_st0 = 1'b1;
      e.due = cyc + MUL_LAT; e.res = m_res; e.rem = m_rem; e.st0 = m_st0; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic go_div(input logic [31:0] n, input logic [15:0] d, input bit sgn,
                        input bit keep, input string tag);
    exp_t e;
    longint sn, sd;
    wr(O_FLG, {7'b0, sgn});
    for (int i = 0; i < 4; i++) wr(O_NUM + 4'(i), n[i*8 +: 8]);
    wr(O_DVS, d[7:0]);
    wr(O_DVS + 4'd1, d[15:8]);
    if (keep) begin
      if (d == 16'h0) begin
        m_res = '0;
        m_rem = n[15:0];
      end else if (sgn) begin
        sn = longint'($signed(n));
        sd = longint'($signed(d));
        m_res = 32'(sn / sd);
        m_rem = 16'(sn % sd);
      end else begin
        m_res = n / {16'b0, d};
        m_rem = 16'(n % {16'b0, d});
      end
      e.due = cyc + DIV_LAT; e.res = m_res; e.rem = m_rem; e.st0 = m_st0; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  // monitor: pops expected items and compares at the due cycle
  task automatic drain();
    exp_t e;
    logic [7:0]  st;
    logic [31:0] r32;
    logic [15:0] r16;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      while (cyc < e.due - 1) @(negedge clk);
      rd(O_STS, st);
      check({"R8 busy before done ", e.tag}, {31'b0, st[7]}, 32'd1);
      while (cyc < e.due) @(negedge clk);
      rd32(O_RES, r32);
      rd16(O_REM, r16);
      rd(O_STS, st);
      check({"result ", e.tag}, r32, e.res);
      check({"remainder ", e.tag}, {16'b0, r16}, {16'b0, e.rem});
      check({"R8 status ", e.tag}, {24'b0, st}, {24'b0, e.st0, 7'b0} >> 7);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of every register
    for (int k = 0; k < 16; k++) begin
      rd(4'(k), b);
      check($sformatf("R1 reg %0d", k), {24'b0, b}, 32'h0);
    end

    // R9 low bytes do not launch
    wr(O_MLT, 8'h12);
    wr(O_DVS, 8'h34);
    repeat (3) @(negedge clk);
    rd(O_STS, b);
    check("R9 low byte no launch status", {24'b0, b}, 32'h0);
    rd32(O_RES, v);
    check("R9 low byte no launch result", v, 32'h0);

    // R2 readback and ignored writes
    for (int i = 0; i < 4; i++) wr(O_NUM + 4'(i), 8'h44 - 8'(i * 8'h11));
    rd32(O_NUM, v);
    check("R2 dividend readback", v, 32'h11223344);
    rd(O_MLT, b);
    check("R2 multiplier low readback", {24'b0, b}, 32'h12);
    wr(O_FLG, 8'hFF);
    rd(O_FLG, b);
    check("R2 mode mask", {24'b0, b}, 32'h01);
    wr(O_RES, 8'h55);
    wr(O_REM + 4'd1, 8'h66);
    wr(O_STS, 8'hFF);
    rd32(O_RES, v);
    check("R2 result write ignored", v, 32'h0);
    rd(O_REM + 4'd1, b);
    check("R2 remainder write ignored", {24'b0, b}, 32'h0);
    rd(O_STS, b);
    check("R2 status write ignored", {24'b0, b}, 32'h0);

    // R5 unsigned divide first, bit 0 must stay clear (R8)
    go_div(32'd1000000, 16'd7, 1'b0, 1'b1, "R5 1e6/7"); drain();
    go_div(32'hFFFFFFFF, 16'd1, 1'b0, 1'b1, "R5 max/1"); drain();
    go_div(32'd5, 16'd9, 1'b0, 1'b1, "R5 5/9"); drain();

    // R3 unsigned multiply
    go_mul(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R3 ffff*ffff"); drain();
    go_mul(16'h1234, 16'h0010, 1'b0, 1'b1, "R3 1234*10"); drain();
    go_mul(16'h0000, 16'hABCD, 1'b0, 1'b1, "R3 zero"); drain();

    // R4 signed multiply
    go_mul(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R4 -1*-1"); drain();
    go_mul(16'h8000, 16'h8000, 1'b1, 1'b1, "R4 min*min"); drain();
    go_mul(16'hFFFD, 16'h0005, 1'b1, 1'b1, "R4 -3*5"); drain();
    go_mul(16'h7FFF, 16'h8000, 1'b1, 1'b1, "R4 max*min"); drain();

    // R6 signed divide
    go_div(32'hFFFFFFF9, 16'd2, 1'b1, 1'b1, "R6 -7/2"); drain();
    go_div(32'd7, 16'hFFFE, 1'b1, 1'b1, "R6 7/-2"); drain();
    go_div(32'h80000000, 16'hFFFF, 1'b1, 1'b1, "R6 min/-1"); drain();
    go_div(32'hFFFFFF9C, 16'hFFF9, 1'b1, 1'b1, "R6 -100/-7"); drain();

    // R7 zero divisor
    go_div(32'h12345678, 16'h0, 1'b0, 1'b1, "R7 unsigned"); drain();
    go_div(32'h80000001, 16'h0, 1'b1, 1'b1, "R7 signed"); drain();

    // R9 operand and mode changes while busy
    go_mul(16'h00FF, 16'h0101, 1'b0, 1'b1, "R9 changes during run");
    wr(O_FLG, 8'h01);
    wr(O_NUM, 8'h00);
    wr(O_MLT, 8'h00);
    drain();

    // R10 restarts
    go_mul(16'h0003, 16'h0004, 1'b0, 1'b0, "");
    repeat (4) @(negedge clk);
    go_mul(16'h0100, 16'h0100, 1'b0, 1'b1, "R10 mul over mul"); drain();
    go_div(32'd100, 16'd3, 1'b0, 1'b0, "");
    go_mul(16'h0007, 16'h0006, 1'b0, 1'b1, "R10 mul over div"); drain();
    go_mul(16'h0009, 16'h0009, 1'b0, 1'b0, "");
    go_div(32'd1000, 16'd33, 1'b0, 1'b1, "R10 div over mul"); drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule